// File: doc/BRIEF.md
# Memory Map Decoder with Keyboard Latch

This block sits on the 16-bit address bus of a small 8-bit processor. It sorts every access into one of three regions: general RAM at the bottom of the map, a page of I/O soft switches, and read-only ROM at the top. Read data leaves on one 8-bit bus one clock after the read request. Writes reach the RAM array only.

A keyboard port feeds a one-byte latch. An arriving key stores its 7-bit code with bit 7 set, which marks a key as pending. Software polls the latch through one I/O address. It acknowledges the key by reading a second I/O address, and that read clears the pending bit. The block therefore has a read that changes state. The RAM and ROM are small behavioural arrays inside the block, and the ROM holds a computed pattern.

Top module: `memmap_kbd_dec`

## Requirements
- R1: An address below 0xC000 selects RAM. A write stores `wdata_i` at index `addr_i[RAM_AW-1:0]`, so RAM aliases across the region. `rdata_o` is registered: it takes the read value on the clock edge where `rd_en_i` is high, and it holds that value while `rd_en_i` is low.
- R2: An address from 0xD000 upward selects ROM. A read returns `addr_i[7:0] XOR ROM_SEED`, with the default `ROM_SEED` of 0xA5 and `ROM_AW` of 8.
- R3: A write to any address at or above 0xC000 is ignored. It changes no RAM byte, including the byte its low address bits alias to. It also leaves the keyboard latch and the ROM contents unchanged.
- R4: A read of exactly 0xC000 returns the keyboard latch value from before the edge. Bit 7 of that value is the key-pending flag.
- R5: A read of exactly 0xC010 returns 0x00 and clears latch bit 7. It leaves bits 6:0 unchanged.
- R6: When `key_valid_i` is high at an edge, the latch loads 0x80 OR the 7-bit key code. This replaces any earlier value.
- R7: Before a key is latched, code 0x0A becomes 0x0D and code 0x7F becomes 0x08.
- R8: A read of any other address in 0xC000–0xCFFF returns 0x00 and leaves the latch unchanged.
- R9: If a key arrives in the same cycle as a read of 0xC010, the new key wins. The latch holds the new code with bit 7 set, and the read itself returns 0x00.
- R10: While `rst_ni` is low, the keyboard latch and `rdata_o` are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Bus address |
| rd_en_i | input | 1 | Read request; data is returned on the next edge |
| wr_en_i | input | 1 | Write request |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| key_valid_i | input | 1 | Key present this cycle |
| key_code_i | input | 7 | Raw key code |

## Verification
The in-line assertions check the following on every cycle:
- the latch loads correctly on a key, including both code translations;
- the latch clears on an acknowledge read and stays stable otherwise;
- an arriving key beats a same-cycle clear;
- the poll and acknowledge reads return the right bytes;
- other I/O reads return zero;
- ROM reads match the pattern;
- `rdata_o` holds when no read is requested.

Only the bench scenarios can show that RAM keeps what was written and that aliasing follows the low address bits. They also show that writes above 0xBFFF leave RAM, the latch and the ROM untouched, because those cases need a later read to expose the stored state.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  typedef enum logic [1:0] {REG_RAM, REG_IO, REG_ROM} region_e;

  localparam logic [15:0] IO_BASE  = 16'hC000;
  localparam logic [15:0] ROM_BASE = 16'hD000;
  localparam logic [15:0] KBD_POLL = 16'hC000;
  localparam logic [15:0] KBD_ACK  = 16'hC010;

  function automatic logic [6:0] map_key(input logic [6:0] code);
    case (code)
      7'h0A:   map_key = 7'h0D;
      7'h7F:   map_key = 7'h08;
      default: map_key = code;
    endcase
  endfunction
endpackage

// File: rtl/mmd_decode.sv
module mmd_decode
  import mmd_pkg::*;
(
  input  logic [15:0] addr_i,
  output region_e     region_o,
  output logic        poll_o,
  output logic        ack_o
);
  always_comb begin
    if (addr_i < IO_BASE)       region_o = REG_RAM;
    else if (addr_i < ROM_BASE) region_o = REG_IO;
    else                        region_o = REG_ROM;
  end

  assign poll_o = (addr_i == KBD_POLL);
  assign ack_o  = (addr_i == KBD_ACK);
endmodule

// File: rtl/mmd_kbd_latch.sv
module mmd_kbd_latch
  import mmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_valid_i,
  input  logic [6:0] key_code_i,
  input  logic       clr_i,
  output logic [7:0] latch_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          latch_o <= 8'h00;
    else if (key_valid_i) latch_o <= {1'b1, map_key(key_code_i)};
    else if (clr_i)       latch_o[7] <= 1'b0;
  end

  // R6
  key_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_i && key_code_i != 7'h0A && key_code_i != 7'h7F
      |=> latch_o == {1'b1, $past(key_code_i)});
  // R7
  key_lf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_i && key_code_i == 7'h0A |=> latch_o == 8'h8D);
  // R7
  key_del_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_i && key_code_i == 7'h7F |=> latch_o == 8'h88);
  // R5
  strobe_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !key_valid_i
      |=> !latch_o[7] && latch_o[6:0] == $past(latch_o[6:0]));
  // R9
  key_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && key_valid_i |=> latch_o[7]);
  // R8
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !key_valid_i |=> $stable(latch_o));
endmodule

// File: rtl/mmd_ram.sv
module mmd_ram #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/mmd_rom.sv
module mmd_rom #(
  parameter int         AW   = 8,
  parameter logic [7:0] SEED = 8'hA5
) (
  input  logic [AW-1:0] addr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] rom_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_fill
    assign rom_w[i] = 8'(i) ^ SEED;
  end

  assign rdata_o = rom_w[addr_i];
endmodule

// File: rtl/memmap_kbd_dec.sv
module memmap_kbd_dec
  import mmd_pkg::*;
#(
  parameter int         RAM_AW   = 8,
  parameter int         ROM_AW   = 8,
  parameter logic [7:0] ROM_SEED = 8'hA5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic        rd_en_i,
  input  logic        wr_en_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        key_valid_i,
  input  logic [6:0]  key_code_i
);
  region_e    region;
  logic       poll, ack;
  logic [7:0] latch, ram_rd, rom_rd;

  mmd_decode u_dec (
    .addr_i  (addr_i),
    .region_o(region),
    .poll_o  (poll),
    .ack_o   (ack)
  );

  mmd_kbd_latch u_kbd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_valid_i(key_valid_i),
    .key_code_i (key_code_i),
    .clr_i      (rd_en_i && ack),
    .latch_o    (latch)
  );

  mmd_ram #(.AW(RAM_AW)) u_ram (
    .clk_i  (clk_i),
    .we_i   (wr_en_i && region == REG_RAM),
    .addr_i (addr_i[RAM_AW-1:0]),
    .wdata_i(wdata_i),
    .rdata_o(ram_rd)
  );

  mmd_rom #(.AW(ROM_AW), .SEED(ROM_SEED)) u_rom (
    .addr_i (addr_i[ROM_AW-1:0]),
    .rdata_o(rom_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= 8'h00;
    else if (rd_en_i) begin
      case (region)
        REG_RAM: rdata_o <= ram_rd;
        REG_IO:  rdata_o <= poll ? latch : 8'h00;
        default: rdata_o <= rom_rd;
      endcase
    end
  end

  // R1
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
  // R2
  rom_pat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i >= 16'hD000
      |=> rdata_o == (8'($past(addr_i[ROM_AW-1:0])) ^ ROM_SEED));
  // R4
  poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == 16'hC000 |=> rdata_o == $past(latch));
  // R5
  ack_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == 16'hC010 |=> rdata_o == 8'h00);
  // R8
  io_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i >= 16'hC000 && addr_i < 16'hD000 && addr_i != 16'hC000
      |=> rdata_o == 8'h00);
endmodule

// File: tb/memmap_kbd_dec_tb.sv
module memmap_kbd_dec_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0, key_valid = 1'b0;
  logic [7:0]  wdata = '0;
  logic [6:0]  key_code = '0;
  logic [7:0]  rdata;

  int vectors = 0, miscompares = 0;
  logic [7:0] m_ram [256];
  logic [7:0] m_lat = 8'h00;
  logic [7:0] m_rd  = 8'h00;

  always #5 clk = ~clk;

  memmap_kbd_dec u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .rd_en_i(rd_en),
    .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata),
    .key_valid_i(key_valid), .key_code_i(key_code)
  );

  function automatic logic [7:0] xlate(input logic [6:0] c);
    if (c == 7'h0A) return 8'h8D;
    if (c == 7'h7F) return 8'h88;
    return {1'b1, c};
  endfunction

  task automatic compare(input string tag);
    vectors++;
    if (rdata !== m_rd) begin
      miscompares++;
      $display("FAIL %s: rdata=%02h expected=%02h", tag, rdata, m_rd);
    end
  endtask

  // called at a negedge; returns at the following negedge after comparing
  task automatic step(input logic [15:0] a, input logic rd, input logic wr,
                      input logic [7:0] wd, input logic kv, input logic [6:0] kc,
                      input string tag);
    int ai;
    addr = a; rd_en = rd; wr_en = wr; wdata = wd; key_valid = kv; key_code = kc;
    @(posedge clk); #1;
    ai = int'(a);
    if (rd) begin
      if (ai < 'hC000)      m_rd = m_ram[ai % 256];
      else if (ai < 'hD000) m_rd = (ai == 'hC000) ? m_lat : 8'h00;
      else                  m_rd = 8'(ai % 256) ^ 8'hA5;
    end
    if (wr && ai < 'hC000) m_ram[ai % 256] = wd;
    if (kv) m_lat = xlate(kc);
    else if (rd && ai == 'hC010) m_lat = m_lat & 8'h7F;
    @(negedge clk);
    rd_en = 0; wr_en = 0; key_valid = 0;
    compare(tag);
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    step(a, 1, 0, 8'h00, 0, 7'h00, tag);
  endtask
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    step(a, 0, 1, d, 0, 7'h00, tag);
  endtask
  task automatic key(input logic [6:0] c, input string tag);
    step(16'h0000, 0, 0, 8'h00, 1, c, tag);
  endtask

  task automatic do_reset(input string tag);
    rst_ni = 0;
    m_lat = 8'h00; m_rd = 8'h00;
    repeat (3) @(negedge clk);
    compare(tag);
    rst_ni = 1;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset("R10 reset");
    rd(16'hC000, "R10 latch clear after reset");

    // RAM
    wr(16'h0012, 8'h3C, "R1");
    wr(16'h1234, 8'h5A, "R1");
    wr(16'hBFFF, 8'hC3, "R1");
    wr(16'h0005, 8'h11, "R1");
    rd(16'h0012, "R1 read back");
    rd(16'h1234, "R1 read back");
    rd(16'hBFFF, "R1 top of RAM");
    step(16'h0012, 0, 0, 8'h00, 0, 7'h00, "R1 hold");
    wr(16'h0134, 8'h99, "R1 alias write");
    rd(16'h1234, "R1 alias read");

    // ROM
    rd(16'hD000, "R2");
    rd(16'hE07F, "R2");
    rd(16'hFFFF, "R2");

    // keyboard
    key(7'h41, "R6");
    rd(16'hC000, "R4 R6 poll");
    rd(16'hC000, "R4 poll again");
    rd(16'hC010, "R5 ack");
    rd(16'hC000, "R5 strobe cleared");
    key(7'h0A, "R7");
    rd(16'hC000, "R7 line feed");
    key(7'h7F, "R7");
    rd(16'hC000, "R7 delete");
    key(7'h20, "R6");
    key(7'h5A, "R6 overwrite");
    rd(16'hC000, "R6 overwrite");

    // other I/O
    rd(16'hC001, "R8");
    rd(16'hC0FF, "R8");
    rd(16'hCFFF, "R8");
    rd(16'hC000, "R8 latch unchanged");

    // ignored writes
    wr(16'hC005, 8'h77, "R3");
    rd(16'h0005, "R3 RAM alias untouched");
    wr(16'hC000, 8'h01, "R3");
    rd(16'hC000, "R3 latch untouched");
    wr(16'hD010, 8'h00, "R3");
    rd(16'hD010, "R3 ROM untouched");
    wr(16'hF034, 8'h00, "R3");
    rd(16'h0034, "R3 RAM alias untouched");

    // key and ack together
    rd(16'hC010, "R5");
    step(16'hC010, 1, 0, 8'h00, 1, 7'h33, "R9 ack returns zero");
    rd(16'hC000, "R9 key wins");

    // reset mid-run
    key(7'h61, "R6");
    do_reset("R10 reset mid-run");
    rd(16'hC000, "R10 latch cleared");
    rd(16'h1234, "R1 after reset");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule